// File: doc/BRIEF.md
# Radio Sleep and Wake Sequencer

This block controls the power state of a radio transceiver. While the radio is awake, it watches for two sleep triggers. The first is a forced-end command written through the SPI configuration path with the end-state field set to zero. The second is the completion of a packet while automatic sleep is enabled. Either trigger puts the block into a pending state. The sleep timer runs on the always-on slow clock that also clocks this block. Every SPI clock rising edge restarts the timer, so sleep begins a fixed, bounded time after the last edge of the issuing transaction. In sleep, the oscillator and the core clock are switched off. The SPI side is not touched and keeps working.

A transmit or receive request wakes the radio. In sleep, the request starts the oscillator and holds the core clock off until the oscillator-ready input has been stable for a set number of cycles. The request is held during that time and is passed to the radio core on the first awake cycle. A wake interrupt can be raised at that point. A request that arrives while sleep is still pending cancels the sleep.

States: AWAKE, SLEEP_PEND, SLEEP, OSC_START. Transitions:
- AWAKE to SLEEP_PEND on a sleep trigger.
- SLEEP_PEND to AWAKE on a request (cancel).
- SLEEP_PEND to SLEEP when the timer expires.
- SLEEP to OSC_START on a request.
- OSC_START to AWAKE when the oscillator is stable.

Top module: `radio_sleep_seq`

## Requirements
- R1: After reset the block is AWAKE with osc_en=1, core_clk_en=1, wake_irq=0 and no start pulses.
- R2: In AWAKE, a cfg_wr with cfg_force_end=1 and cfg_end_state=3'b000 moves the block to SLEEP_PEND. A write with any other end-state value has no effect.
- R3: SLEEP is entered after exactly EFF_DLY consecutive clock cycles in SLEEP_PEND without an sck_rise. EFF_DLY is SLEEP_DLY clamped to the number of slow-clock cycles in 35 µs, and is at least 1.
- R4: Each sck_rise in SLEEP_PEND restarts the sleep count from zero.
- R5: In AWAKE, pkt_done moves the block to SLEEP_PEND only when auto_sleep_en=1. Otherwise it is ignored.
- R6: In SLEEP, osc_en=0 and core_clk_en=0. In SLEEP_PEND both stay 1. In SLEEP, further sleep triggers are ignored.
- R7: tx_go or rx_go in SLEEP moves the block to OSC_START, where osc_en=1 and core_clk_en=0.
- R8: OSC_START moves to AWAKE on the RDY_CNT-th consecutive cycle with osc_rdy=1. A low osc_rdy resets the run.
- R9: tx_go or rx_go in SLEEP_PEND cancels the sleep and returns the block to AWAKE.
- R10: A request that arrives outside AWAKE is held and issued as a one-cycle tx_start or rx_start on the first AWAKE cycle. In AWAKE, a request passes straight through in the same cycle. A transmit request takes priority over a receive request.
- R11: wake_irq is set on the OSC_START to AWAKE transition when wake_irq_en=1. It holds until irq_clr. It is never set when wake_irq_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe: transaction configuration fields written |
| cfg_force_end | input | 1 | Force-end field of the write |
| cfg_end_state | input | 3 | End-state field of the write; 000 selects sleep |
| sck_rise | input | 1 | One-cycle pulse per SPI clock rising edge |
| auto_sleep_en | input | 1 | Enter sleep after a completed packet |
| pkt_done | input | 1 | Packet transmission or reception completed |
| tx_go | input | 1 | Request to enter transmit mode |
| rx_go | input | 1 | Request to enter receive mode |
| osc_rdy | input | 1 | Oscillator-ready indication |
| wake_irq_en | input | 1 | Enable the wake interrupt |
| irq_clr | input | 1 | Clear the wake interrupt |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Radio core clock gate enable |
| wake_irq | output | 1 | Oscillator-stable wake interrupt |
| tx_start | output | 1 | One-cycle transmit start to the radio core |
| rx_start | output | 1 | One-cycle receive start to the radio core |

## Verification
The embedded properties check the following on every cycle:
- SLEEP is reached only from SLEEP_PEND, and only with the timer expired.
- AWAKE is left from OSC_START only after a sampled osc_rdy.
- An osc_rdy drop clears the stability count.
- The interrupt rises only on the wake transition.
- The two start outputs are never high together.

Only the directed scenarios can show the following:
- The exact cycle counts of the sleep delay, and the restart of that delay by SPI edges.
- The rejection of non-zero end states and of pkt_done while auto sleep is off.
- Cancellation during SLEEP_PEND.
- The transmit-over-receive priority of held requests.

// File: rtl/rss_pkg.sv
package rss_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE      = 2'd0,
        ST_SLEEP_PEND = 2'd1,
        ST_SLEEP      = 2'd2,
        ST_OSC_START  = 2'd3
    } rss_state_e;

    localparam logic [2:0] END_STATE_SLEEP = 3'b000;
endpackage

// File: rtl/sleep_dly_timer.sv
module sleep_dly_timer #(
    parameter int DLY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && !restart && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // R4: an SPI edge always leaves the count at zero
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (cnt_q == '0));
endmodule

// File: rtl/osc_rdy_filter.sv
module osc_rdy_filter #(
    parameter int RDY_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_rdy,
    output logic stable
);
    localparam int CW = (RDY_CNT < 2) ? 1 : $clog2(RDY_CNT);
    localparam logic [CW-1:0] LAST = CW'(RDY_CNT - 1);

    logic [CW-1:0] cnt_q;

    assign stable = run && osc_rdy && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || !osc_rdy)
            cnt_q <= '0;
        else if (!stable)
            cnt_q <= cnt_q + 1'b1;
    end

    // R8: a dropped ready restarts the consecutive run
    p_drop_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_rdy) |=> (cnt_q == '0));
endmodule

// File: rtl/wake_req_hold.sv
module wake_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic issue,
    input  logic tx_go,
    input  logic rx_go,
    output logic tx_start,
    output logic rx_start
);
    logic held_tx_q, held_rx_q;

    assign tx_start = issue && (held_tx_q || tx_go);
    assign rx_start = issue && !tx_start && (held_rx_q || rx_go);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_tx_q <= 1'b0;
            held_rx_q <= 1'b0;
        end else if (issue) begin
            held_tx_q <= 1'b0;
            held_rx_q <= 1'b0;
        end else if (capture) begin
            if (tx_go) begin
                held_tx_q <= 1'b1;
                held_rx_q <= 1'b0;
            end else if (rx_go && !held_tx_q) begin
                held_rx_q <= 1'b1;
            end
        end
    end

    // R10: at most one start per cycle
    p_start_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_start, rx_start}));
    // R10: a held request is consumed on issue
    p_issue_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (!held_tx_q && !held_rx_q));
endmodule

// File: rtl/radio_sleep_seq.sv
module radio_sleep_seq #(
    parameter int SLOW_CLK_KHZ = 1000,
    parameter int SLEEP_DLY    = 20,
    parameter int RDY_CNT      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_force_end,
    input  logic [2:0] cfg_end_state,
    input  logic       sck_rise,
    input  logic       auto_sleep_en,
    input  logic       pkt_done,
    input  logic       tx_go,
    input  logic       rx_go,
    input  logic       osc_rdy,
    input  logic       wake_irq_en,
    input  logic       irq_clr,
    output logic       osc_en,
    output logic       core_clk_en,
    output logic       wake_irq,
    output logic       tx_start,
    output logic       rx_start
);
    import rss_pkg::*;

    localparam int MAX_DLY  = (35 * SLOW_CLK_KHZ) / 1000;
    localparam int CLMP_DLY = (SLEEP_DLY > MAX_DLY) ? MAX_DLY : SLEEP_DLY;
    localparam int EFF_DLY  = (CLMP_DLY < 1) ? 1 : CLMP_DLY;

    rss_state_e state_q, state_d;
    logic sleep_cmd, wake_req, tmr_expired, osc_stable, irq_q;

    assign sleep_cmd = (cfg_wr && cfg_force_end && (cfg_end_state == END_STATE_SLEEP))
                     || (auto_sleep_en && pkt_done);
    assign wake_req  = tx_go || rx_go;

    sleep_dly_timer #(.DLY(EFF_DLY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SLEEP_PEND),
        .restart (sck_rise),
        .expired (tmr_expired)
    );

    osc_rdy_filter #(.RDY_CNT(RDY_CNT)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_OSC_START),
        .osc_rdy (osc_rdy),
        .stable  (osc_stable)
    );

    wake_req_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (state_q != ST_AWAKE),
        .issue    (state_q == ST_AWAKE),
        .tx_go    (tx_go),
        .rx_go    (rx_go),
        .tx_start (tx_start),
        .rx_start (rx_start)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:      if (!wake_req && sleep_cmd) state_d = ST_SLEEP_PEND;
            ST_SLEEP_PEND: if (wake_req)               state_d = ST_AWAKE;
                           else if (tmr_expired)       state_d = ST_SLEEP;
            ST_SLEEP:      if (wake_req)               state_d = ST_OSC_START;
            ST_OSC_START:  if (osc_stable)             state_d = ST_AWAKE;
            default:                                   state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_AWAKE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (state_q == ST_OSC_START && osc_stable && wake_irq_en)
            irq_q <= 1'b1;
        else if (irq_clr)
            irq_q <= 1'b0;
    end

    always_comb begin
        osc_en      = 1'b1;
        core_clk_en = 1'b1;
        unique case (state_q)
            ST_AWAKE:      begin osc_en = 1'b1; core_clk_en = 1'b1; end
            ST_SLEEP_PEND: begin osc_en = 1'b1; core_clk_en = 1'b1; end
            ST_SLEEP:      begin osc_en = 1'b0; core_clk_en = 1'b0; end
            ST_OSC_START:  begin osc_en = 1'b1; core_clk_en = 1'b0; end
            default:       begin osc_en = 1'b1; core_clk_en = 1'b1; end
        endcase
    end
    assign wake_irq = irq_q;

    // R3: sleep only follows an expired pending window
    p_sleep_after_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |->
        ($past(state_q) == ST_SLEEP_PEND && $past(tmr_expired)));
    // R8: wake completes only on a sampled ready oscillator
    p_wake_needs_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAKE && $past(state_q) == ST_OSC_START) |-> $past(osc_rdy));
    // R11: interrupt rises only on the startup-to-awake step
    p_irq_on_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> (state_q == ST_AWAKE && $past(state_q) == ST_OSC_START
                              && $past(wake_irq_en)));
    // R6: the oscillator stays stopped across a held sleep
    p_sleep_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !tx_go && !rx_go) |=> !osc_en);
endmodule

// File: tb/test_radio_sleep_seq.sv
module test_radio_sleep_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_force_end = 0, sck_rise = 0, auto_sleep_en = 0, pkt_done = 0;
    logic tx_go = 0, rx_go = 0, osc_rdy = 0, wake_irq_en = 0, irq_clr = 0;
    logic [2:0] cfg_end_state = 3'b000;
    logic osc_en, core_clk_en, wake_irq, tx_start, rx_start;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    radio_sleep_seq #(.SLOW_CLK_KHZ(1000), .SLEEP_DLY(20), .RDY_CNT(4)) i_radio_sleep_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_force_end(cfg_force_end),
        .cfg_end_state(cfg_end_state), .sck_rise(sck_rise), .auto_sleep_en(auto_sleep_en),
        .pkt_done(pkt_done), .tx_go(tx_go), .rx_go(rx_go), .osc_rdy(osc_rdy),
        .wake_irq_en(wake_irq_en), .irq_clr(irq_clr), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .wake_irq(wake_irq), .tx_start(tx_start), .rx_start(rx_start));

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cmd_sleep(logic [2:0] es);
        cfg_wr = 1; cfg_force_end = 1; cfg_end_state = es;
        step();
        cfg_wr = 0; cfg_force_end = 0; cfg_end_state = 3'b000;
    endtask

    task automatic t_reset();
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "core_clk_en", core_clk_en, 1);
        chk("R1", "wake_irq", wake_irq, 0);
        chk("R1", "tx_start", tx_start, 0);
    endtask

    task automatic t_force_sleep();
        cmd_sleep(3'b000);
        chk("R6", "pending core clock", core_clk_en, 1);
        repeat (19) step();
        chk("R3", "osc before expiry", osc_en, 1);
        step();
        chk("R3", "osc at expiry", osc_en, 0);
        chk("R6", "core clock in sleep", core_clk_en, 0);
        cmd_sleep(3'b000);
        chk("R6", "sleep cmd in sleep", osc_en, 0);
    endtask

    task automatic t_wake_rx();
        wake_irq_en = 1; osc_rdy = 0;
        rx_go = 1; step(); rx_go = 0;
        chk("R7", "osc_en in startup", osc_en, 1);
        chk("R7", "core off in startup", core_clk_en, 0);
        repeat (5) step();
        chk("R8", "no ready stays off", core_clk_en, 0);
        osc_rdy = 1; step(); step();
        osc_rdy = 0; step();
        osc_rdy = 1; repeat (3) step();
        chk("R8", "glitch restarts run", core_clk_en, 0);
        step();
        chk("R8", "awake after run", core_clk_en, 1);
        chk("R10", "held rx issued", rx_start, 1);
        chk("R10", "no tx", tx_start, 0);
        chk("R11", "irq set", wake_irq, 1);
        step();
        chk("R10", "rx single pulse", rx_start, 0);
        chk("R11", "irq held", wake_irq, 1);
        irq_clr = 1; step(); irq_clr = 0;
        chk("R11", "irq cleared", wake_irq, 0);
    endtask

    task automatic t_sck_extend();
        cmd_sleep(3'b000);
        repeat (10) step();
        sck_rise = 1; step(); sck_rise = 0;
        repeat (19) step();
        chk("R4", "sck restarts delay", osc_en, 1);
        step();
        chk("R4", "sleep after restart", osc_en, 0);
    endtask

    task automatic t_bad_end_state();
        cmd_sleep(3'b101);
        repeat (25) step();
        chk("R2", "nonzero end state ignored", osc_en, 1);
        chk("R2", "core stays on", core_clk_en, 1);
    endtask

    task automatic t_cancel();
        cmd_sleep(3'b000);
        repeat (5) step();
        tx_go = 1; step(); tx_go = 0;
        chk("R10", "held tx on first awake", tx_start, 1);
        step();
        chk("R10", "tx single pulse", tx_start, 0);
        repeat (25) step();
        chk("R9", "cancel keeps osc", osc_en, 1);
        rx_go = 1; #1;
        chk("R10", "pass-through rx", rx_start, 1);
        step(); rx_go = 0;
    endtask

    task automatic t_auto();
        auto_sleep_en = 0; pkt_done = 1; step(); pkt_done = 0;
        repeat (25) step();
        chk("R5", "pkt_done ignored", osc_en, 1);
        auto_sleep_en = 1; pkt_done = 1; step(); pkt_done = 0; auto_sleep_en = 0;
        repeat (20) step();
        chk("R5", "auto sleep", osc_en, 0);
    endtask

    task automatic t_prio();
        wake_irq_en = 0; osc_rdy = 1;
        tx_go = 1; rx_go = 1; step(); tx_go = 0; rx_go = 0;
        repeat (3) step();
        chk("R8", "startup not done", core_clk_en, 0);
        step();
        chk("R8", "awake", core_clk_en, 1);
        chk("R10", "tx wins", tx_start, 1);
        chk("R10", "rx dropped", rx_start, 0);
        chk("R11", "irq disabled", wake_irq, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        step();
        t_reset();
        t_force_sleep();
        t_wake_rx();
        t_sck_extend();
        t_prio();
        t_bad_end_state();
        t_cancel();
        t_auto();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule